// File: doc/BRIEF.md
# Address-Match Busy Arbiter

This block sits in front of a dual-port memory and watches the two ports' selects. When both ports are enabled on the same address at the same time, it grants the location to one port and drives an active-low busy flag to the other. While that port's busy flag is low, its writes are blocked. Reads on the blocked port are not gated. The arbitration looks only at chip enables and address equality. Whether an access is a read or a write plays no part in it.

The winner is the port whose request was already present, with the same address, in the previous clock. If both requests appear in the same clock, the left port wins. The winner is kept in a register for as long as the match lasts, so a granted port is never pre-empted. A mode input turns the block into a follower. In that mode it arbitrates nothing, holds its own busy outputs high, and uses the busy inputs supplied by a leading instance only as write inhibits. Several followers sharing one leader's decision can therefore widen the data bus without a split decision between the parts. Software must let busy settle before starting a write pulse, so a write cycle takes the busy latency plus the pulse.

The control core is a three-state machine:
- **ST_FREE**: no conflict.
- **ST_LEFT_OWNS**: the left port won, so right busy is low.
- **ST_RIGHT_OWNS**: the right port won, so left busy is low.

The transitions are:
- **FREE→LEFT_OWNS**: a new match where the left request was held from the previous cycle and the right request was not, or both requests are new, or both were held.
- **FREE→RIGHT_OWNS**: a new match where only the right request was held.
- **OWNS→FREE**: the match ends, or follower mode is selected.
- **OWNS→same**: the match continues.

Top module: `mem_busy_arbiter`

## Requirements
- R1: During and directly after reset, both busy outputs are high and neither write inhibit is active.
- R2: When the addresses differ, or either chip enable is high (inactive), both busy outputs are high one clock later.
- R3: When a matching request from the right port appears while the left port has held the same enabled address since the previous clock, right busy goes low one clock later and left busy stays high.
- R4: When a matching request from the left port appears while the right port has held the same enabled address since the previous clock, left busy goes low one clock later and right busy stays high.
- R5: When both ports present a new matching request in the same clock, the left port wins, so right busy goes low one clock later.
- R6: The two busy outputs are never low at the same time.
- R7: The write-enable inputs (active low) have no effect on either busy output.
- R8: While the match lasts, the winner is kept, even if both ports move together to a new common address.
- R9: Busy returns high one clock after the match ends.
- R10: A port's write strobe is high exactly when its chip enable and write enable are low and its write inhibit is inactive. In leader mode a port's inhibit is active exactly while its own busy output is low.
- R11: In follower mode (slave_mode = 1), both busy outputs are high. Each port's write inhibit then equals the inverse of that port's busy input, in the same cycle, and no arbitration takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = follower: busy comes from outside and only inhibits writes |
| lt_ce_n | input | 1 | Left chip enable, active low |
| lt_addr | input | ADDR_W | Left address |
| lt_we_n | input | 1 | Left write enable, active low |
| lt_busy_in_n | input | 1 | Left busy from a leader, used in follower mode |
| rt_ce_n | input | 1 | Right chip enable, active low |
| rt_addr | input | ADDR_W | Right address |
| rt_we_n | input | 1 | Right write enable, active low |
| rt_busy_in_n | input | 1 | Right busy from a leader, used in follower mode |
| lt_busy_n | output | 1 | Left busy, active low |
| rt_busy_n | output | 1 | Right busy, active low |
| lt_wr_inhibit | output | 1 | Left write blocked |
| rt_wr_inhibit | output | 1 | Right write blocked |
| lt_wr_go | output | 1 | Gated left write strobe to the memory |
| rt_wr_go | output | 1 | Gated right write strobe to the memory |

## Verification
Busy decisions are registered. Their effect, and the leader-mode inhibit that follows them, appears one clock after the inputs present at an edge. The follower-mode inhibit and the gated write strobes depend on the current inputs in the same cycle. The bench drives inputs 1 ns after a rising edge and compares every output at the following falling edge. Its reference model updates its owner at each rising edge from the inputs present then, which matches the one-clock busy latency and the same-cycle strobe paths.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_FREE       = 2'd0,
        ST_LEFT_OWNS  = 2'd1,
        ST_RIGHT_OWNS = 2'd2
    } own_state_t;

    localparam int NUM_PORTS = 2;
    localparam int P_LT = 0;
    localparam int P_RT = 1;
endpackage

// File: rtl/port_tracker.sv
// Remembers one port's previous select so the arbiter can tell whether
// the current request was already stable in the prior clock.
module port_tracker #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              held
);
    logic              prev_en;
    logic [ADDR_W-1:0] prev_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_en   <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_en   <= !ce_n;
            prev_addr <= addr;
        end
    end

    assign held = !ce_n && prev_en && (prev_addr == addr);
endmodule

// File: rtl/arb_fsm.sv
// Ownership state machine: free, left owns, right owns.
module arb_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slave_mode,
    input  logic       match,
    input  logic       lt_held,
    input  logic       rt_held,
    output own_state_t state
);
    own_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FREE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (slave_mode) begin
            state_nx = ST_FREE;
        end else begin
            unique case (state)
                ST_FREE: begin
                    if (match) begin
                        if (rt_held && !lt_held) state_nx = ST_RIGHT_OWNS;
                        else                     state_nx = ST_LEFT_OWNS;
                    end
                end
                ST_LEFT_OWNS:  if (!match) state_nx = ST_FREE;
                ST_RIGHT_OWNS: if (!match) state_nx = ST_FREE;
                default:       state_nx = ST_FREE;
            endcase
        end
    end
endmodule

// File: rtl/wr_gate.sv
// Passes a port's write strobe only when no inhibit is active.
module wr_gate (
    input  logic ce_n,
    input  logic we_n,
    input  logic inhibit,
    output logic wr_go
);
    assign wr_go = !ce_n && !we_n && !inhibit;
endmodule

// File: rtl/mem_busy_arbiter.sv
module mem_busy_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              lt_ce_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_we_n,
    input  logic              lt_busy_in_n,
    input  logic              rt_ce_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_we_n,
    input  logic              rt_busy_in_n,
    output logic              lt_busy_n,
    output logic              rt_busy_n,
    output logic              lt_wr_inhibit,
    output logic              rt_wr_inhibit,
    output logic              lt_wr_go,
    output logic              rt_wr_go
);
    logic [NUM_PORTS-1:0]             ce_n_v, we_n_v, held_v, inh_v, go_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic                             match;
    own_state_t                       state;

    assign ce_n_v = {rt_ce_n, lt_ce_n};
    assign we_n_v = {rt_we_n, lt_we_n};
    assign addr_v = {rt_addr, lt_addr};
    assign match  = !lt_ce_n && !rt_ce_n && (lt_addr == rt_addr);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_tracker #(.ADDR_W(ADDR_W)) u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .ce_n  (ce_n_v[p]),
            .addr  (addr_v[p]),
            .held  (held_v[p])
        );
        wr_gate u_gate (
            .ce_n    (ce_n_v[p]),
            .we_n    (we_n_v[p]),
            .inhibit (inh_v[p]),
            .wr_go   (go_v[p])
        );
    end

    arb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (slave_mode),
        .match      (match),
        .lt_held    (held_v[P_LT]),
        .rt_held    (held_v[P_RT]),
        .state      (state)
    );

    // Output decode from the state register.
    always_comb begin
        lt_busy_n = 1'b1;
        rt_busy_n = 1'b1;
        if (!slave_mode) begin
            unique case (state)
                ST_FREE:       ;
                ST_LEFT_OWNS:  rt_busy_n = 1'b0;
                ST_RIGHT_OWNS: lt_busy_n = 1'b0;
                default:       ;
            endcase
            inh_v[P_LT] = !lt_busy_n;
            inh_v[P_RT] = !rt_busy_n;
        end else begin
            inh_v[P_LT] = !lt_busy_in_n;
            inh_v[P_RT] = !rt_busy_in_n;
        end
    end

    assign lt_wr_inhibit = inh_v[P_LT];
    assign rt_wr_inhibit = inh_v[P_RT];
    assign lt_wr_go      = go_v[P_LT];
    assign rt_wr_go      = go_v[P_RT];
endmodule

// File: rtl/mem_busy_arbiter_chk.sv
module mem_busy_arbiter_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              lt_ce_n,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              rt_ce_n,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              lt_busy_in_n,
    input logic              lt_busy_n,
    input logic              rt_busy_n,
    input logic              lt_wr_go
);
    logic same_sel;
    assign same_sel = !lt_ce_n && !rt_ce_n && (lt_addr == rt_addr);

    // R6
    never_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lt_busy_n && !rt_busy_n));

    // R2
    no_match_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !same_sel |=> (lt_busy_n && rt_busy_n));

    // R8
    winner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_busy_n && same_sel && !slave_mode) |=> (slave_mode || !rt_busy_n));

    // R10
    busy_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !lt_busy_n) |-> !lt_wr_go);

    // R11
    follower_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (lt_busy_n && rt_busy_n));

    // R11
    follower_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && !lt_busy_in_n) |-> !lt_wr_go);
endmodule

bind mem_busy_arbiter mem_busy_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slave_mode   (slave_mode),
    .lt_ce_n      (lt_ce_n),
    .lt_addr      (lt_addr),
    .rt_ce_n      (rt_ce_n),
    .rt_addr      (rt_addr),
    .lt_busy_in_n (lt_busy_in_n),
    .lt_busy_n    (lt_busy_n),
    .rt_busy_n    (rt_busy_n),
    .lt_wr_go     (lt_wr_go)
);

// File: tb/sim_mem_busy_arbiter.sv
`timescale 1ns/1ps
module sim_mem_busy_arbiter;
    localparam int AW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slave_mode = 1'b0;
    logic lt_ce_n = 1'b1, rt_ce_n = 1'b1, lt_we_n = 1'b1, rt_we_n = 1'b1;
    logic lt_busy_in_n = 1'b1, rt_busy_in_n = 1'b1;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic lt_busy_n, rt_busy_n, lt_wr_inhibit, rt_wr_inhibit, lt_wr_go, rt_wr_go;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference model state: 0 none, 1 left owns, 2 right owns
    int owner = 0;
    bit m_lprev_en = 0, m_rprev_en = 0;
    logic [AW-1:0] m_lprev_a = '0, m_rprev_a = '0;

    always #2 clk = ~clk;

    mem_busy_arbiter #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .lt_ce_n(lt_ce_n), .lt_addr(lt_addr), .lt_we_n(lt_we_n), .lt_busy_in_n(lt_busy_in_n),
        .rt_ce_n(rt_ce_n), .rt_addr(rt_addr), .rt_we_n(rt_we_n), .rt_busy_in_n(rt_busy_in_n),
        .lt_busy_n(lt_busy_n), .rt_busy_n(rt_busy_n),
        .lt_wr_inhibit(lt_wr_inhibit), .rt_wr_inhibit(rt_wr_inhibit),
        .lt_wr_go(lt_wr_go), .rt_wr_go(rt_wr_go)
    );

    always @(posedge clk) begin
        bit m, lh, rh;
        if (!rst_n) begin
            owner = 0; m_lprev_en = 0; m_rprev_en = 0; m_lprev_a = '0; m_rprev_a = '0;
        end else begin
            m  = !lt_ce_n && !rt_ce_n && (lt_addr == rt_addr);
            lh = !lt_ce_n && m_lprev_en && (m_lprev_a == lt_addr);
            rh = !rt_ce_n && m_rprev_en && (m_rprev_a == rt_addr);
            if (slave_mode || !m) owner = 0;
            else if (owner == 0) owner = (rh && !lh) ? 2 : 1;
            m_lprev_en = !lt_ce_n; m_rprev_en = !rt_ce_n;
            m_lprev_a = lt_addr;   m_rprev_a = rt_addr;
        end
    end

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic eb_l, eb_r, ei_l, ei_r;
        if (!rst_n) begin
            chk("reset lt_busy_n (R1)", lt_busy_n, 1'b1);
            chk("reset rt_busy_n (R1)", rt_busy_n, 1'b1);
        end else begin
            eb_l = slave_mode ? 1'b1 : (owner != 2);
            eb_r = slave_mode ? 1'b1 : (owner != 1);
            ei_l = slave_mode ? !lt_busy_in_n : !eb_l;
            ei_r = slave_mode ? !rt_busy_in_n : !eb_r;
            chk("lt_busy_n", lt_busy_n, eb_l);
            chk("rt_busy_n", rt_busy_n, eb_r);
            chk("lt_wr_inhibit", lt_wr_inhibit, ei_l);
            chk("rt_wr_inhibit", rt_wr_inhibit, ei_r);
            chk("lt_wr_go (R10)", lt_wr_go, !lt_ce_n && !lt_we_n && !ei_l);
            chk("rt_wr_go (R10)", rt_wr_go, !rt_ce_n && !rt_we_n && !ei_r);
            chk("not both busy (R6)", !(lt_busy_n === 1'b0 && rt_busy_n === 1'b0), 1'b1);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic idle_both();
        lt_ce_n = 1; rt_ce_n = 1; lt_we_n = 1; rt_we_n = 1;
    endtask

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tag = "R1";
        tick(3);
        rst_n = 1; tick(2);

        // R2: different addresses, and one side disabled
        tag = "R2";
        lt_ce_n = 0; lt_addr = 11'h010; rt_ce_n = 0; rt_addr = 11'h011; tick(3);
        rt_addr = 11'h010; rt_ce_n = 1; tick(3);
        idle_both(); tick(2);

        // R3: left stable first, right arrives
        tag = "R3";
        lt_ce_n = 0; lt_addr = 11'h123; tick(2);
        rt_ce_n = 0; rt_addr = 11'h123; tick(4);
        // R10: right tries to write while busy, left writes freely
        tag = "R10";
        rt_we_n = 0; lt_we_n = 0; tick(2);
        lt_we_n = 1; rt_we_n = 1;
        // R9: match ends by address change
        tag = "R9";
        rt_addr = 11'h124; tick(3);
        idle_both(); tick(2);

        // R4: right stable first
        tag = "R4";
        rt_ce_n = 0; rt_addr = 11'h7FE; tick(2);
        lt_ce_n = 0; lt_addr = 11'h7FE; tick(3);
        tag = "R10";
        lt_we_n = 0; rt_we_n = 0; tick(2);
        lt_we_n = 1; rt_we_n = 1;
        // R8: both move together; right keeps ownership
        tag = "R8";
        lt_addr = 11'h055; rt_addr = 11'h055; tick(4);
        // R9: competing enable goes high
        tag = "R9";
        rt_ce_n = 1; tick(3);
        idle_both(); tick(2);

        // R5: both new in the same clock
        tag = "R5";
        lt_ce_n = 0; rt_ce_n = 0; lt_addr = 11'h3A0; rt_addr = 11'h3A0; tick(4);
        // R7: write enables toggle without moving busy
        tag = "R7";
        for (int i = 0; i < 6; i++) begin
            lt_we_n = i[0]; rt_we_n = i[1]; tick(1);
        end
        idle_both(); tick(2);
        // R7: a write-only request is arbitrated the same as a read
        lt_we_n = 0; lt_ce_n = 0; lt_addr = 11'h0FF; tick(2);
        rt_ce_n = 0; rt_addr = 11'h0FF; tick(3);
        idle_both(); tick(2);

        // R11: follower mode
        tag = "R11";
        slave_mode = 1;
        lt_ce_n = 0; rt_ce_n = 0; lt_addr = 11'h200; rt_addr = 11'h200; tick(3);
        lt_we_n = 0; rt_we_n = 0;
        lt_busy_in_n = 0; tick(2);
        lt_busy_in_n = 1; rt_busy_in_n = 0; tick(2);
        rt_busy_in_n = 1; tick(2);
        // R11: leaving follower mode with a standing match, fresh arbitration
        slave_mode = 0; lt_we_n = 1; rt_we_n = 1; tick(4);
        idle_both(); tick(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule